// File: doc/BRIEF.md
# Banked Nibble Data Memory with Status Characters

This block is the data store of a 4-bit processor. A selection command loads an 8-bit address into a latch. That address splits into a chip field, a register field and a character field. A separate bank command chooses one of several independent groups of chips. Every read and write after that goes to the latched location. The latch keeps its value until the next selection command replaces it, so one selection can serve a series of accesses.

Each register holds sixteen main characters and four status characters. Each status character has its own write strobe and its own read strobe. A status character is located by chip and register only. Main and status storage are separate arrays, so writing one never changes the other. Reads are registered: the output nibble keeps its last value until another read strikes.

Top module: `nibram_banked`

## Requirements
- R1: A pulse on `sel_ld` captures `sel_in`, and every access from the next cycle on uses that address until the next pulse. An access in the same cycle as `sel_ld` still uses the previous address.
- R2: The address splits as bits [7:6] chip, bits [5:4] register and bits [3:0] main character. Any two different addresses reach different main characters.
- R3: A pulse on `bank_ld` loads the 3-bit `bank_val`. The bank holds until the next pulse, and all eight values select distinct storage.
- R4: The same address in two different banks reaches two independent characters.
- R5: One cycle after `main_rd`, `rdata` shows the main character at the latched bank and address. Without a read strobe, `rdata` holds its value, even when a write changes memory.
- R6: Each register has four status characters numbered 0 to 3. `stat_wr[n]` writes status character n and `stat_rd[n]` reads it; n is the bit position in the strobe vector.
- R7: Status accesses ignore address bits [3:0]. Two addresses that differ only in those bits reach the same status character.
- R8: Main characters and status characters are separate storage, and writing one leaves the other unchanged.
- R9: Reset sets the bank to 0, the address latch to 0 and `rdata` to 0. Reset does not clear memory contents.
- R10: A read in the same cycle as a write to the same location returns the old content. `main_rd` wins over `stat_rd`, and among several `stat_rd` bits the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_ld | input | 1 | Load strobe for the address latch |
| sel_in | input | 8 | Address: chip [7:6], register [5:4], character [3:0] |
| bank_ld | input | 1 | Load strobe for the bank register |
| bank_val | input | 3 | Bank number |
| main_wr | input | 1 | Write `wdata` to the selected main character |
| main_rd | input | 1 | Read the selected main character |
| stat_wr | input | 4 | Bit n writes status character n of the selected register |
| stat_rd | input | 4 | Bit n reads status character n of the selected register |
| wdata | input | 4 | Write nibble |
| rdata | output | 4 | Registered read nibble |

## Verification
The address latch and the bank register take effect in the cycle after their strobe. A read result appears on `rdata` exactly one clock edge after the read strobe. The bench drives every strobe for one cycle from a falling edge and drops it at the next falling edge. It samples `rdata` at that second falling edge, which is half a cycle after the single register stage has updated. The directed cases for same-cycle load and read, and for write and read together, use the same timing to show that the value sampled belongs to the state before the edge.

// File: rtl/nibram_pkg.sv
package nibram_pkg;
  localparam int NIB_W  = 4;
  localparam int CHIP_W = 2;
  localparam int REG_W  = 2;
  localparam int CHAR_W = 4;
  localparam int SEL_W  = CHIP_W + REG_W + CHAR_W;
  localparam int STAT_N = 4;

  typedef struct packed {
    logic [CHIP_W-1:0] chip;
    logic [REG_W-1:0]  rgs;
    logic [CHAR_W-1:0] chr;
  } sel_t;
endpackage

// File: rtl/nibram_sel_regs.sv
module nibram_sel_regs
  import nibram_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_ld,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              bank_ld,
  input  logic [BANK_W-1:0] bank_val,
  output sel_t              sel_q,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      bank_q <= '0;
    end else begin
      if (sel_ld)  sel_q  <= sel_t'(sel_in);
      if (bank_ld) bank_q <= bank_val;
    end
  end
endmodule

// File: rtl/nibram_store.sv
module nibram_store #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/nibram_banked.sv
module nibram_banked
  import nibram_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_ld,
  input  logic [7:0]        sel_in,
  input  logic              bank_ld,
  input  logic [BANK_W-1:0] bank_val,
  input  logic              main_wr,
  input  logic              main_rd,
  input  logic [3:0]        stat_wr,
  input  logic [3:0]        stat_rd,
  input  logic [3:0]        wdata,
  output logic [3:0]        rdata
);
  localparam int MAIN_AW = BANK_W + SEL_W;
  localparam int STAT_AW = BANK_W + CHIP_W + REG_W;

  function automatic logic [MAIN_AW-1:0] main_index(input logic [BANK_W-1:0] b, input sel_t s);
    return {b, s.chip, s.rgs, s.chr};
  endfunction

  function automatic logic [STAT_AW-1:0] stat_index(input logic [BANK_W-1:0] b, input sel_t s);
    return {b, s.chip, s.rgs};
  endfunction

  sel_t              sel_q;
  logic [BANK_W-1:0] bank_q;
  logic [MAIN_AW-1:0] main_idx;
  logic [STAT_AW-1:0] stat_idx;
  logic [NIB_W-1:0]  main_q;
  logic [NIB_W-1:0]  stat_q [STAT_N];
  logic              rd_hit;
  logic [NIB_W-1:0]  rd_val;

  nibram_sel_regs #(.BANK_W(BANK_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_ld   (sel_ld),
    .sel_in   (sel_in),
    .bank_ld  (bank_ld),
    .bank_val (bank_val),
    .sel_q    (sel_q),
    .bank_q   (bank_q)
  );

  assign main_idx = main_index(bank_q, sel_q);
  assign stat_idx = stat_index(bank_q, sel_q);

  nibram_store #(.AW(MAIN_AW), .DW(NIB_W)) u_main (
    .clk   (clk),
    .we    (main_wr),
    .addr  (main_idx),
    .wdata (wdata),
    .rdata (main_q)
  );

  for (genvar g = 0; g < STAT_N; g++) begin : g_stat
    nibram_store #(.AW(STAT_AW), .DW(NIB_W)) u_stat (
      .clk   (clk),
      .we    (stat_wr[g]),
      .addr  (stat_idx),
      .wdata (wdata),
      .rdata (stat_q[g])
    );
  end

  // main read first, then the lowest status index
  always_comb begin
    rd_hit = main_rd | (|stat_rd);
    rd_val = '0;
    for (int i = STAT_N - 1; i >= 0; i--) begin
      if (stat_rd[i]) rd_val = stat_q[i];
    end
    if (main_rd) rd_val = main_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_hit) rdata <= rd_val;
  end
endmodule

// File: rtl/nibram_banked_chk.sv
module nibram_banked_chk #(
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_ld,
  input logic [7:0]        sel_in,
  input logic              bank_ld,
  input logic [BANK_W-1:0] bank_val,
  input logic              main_rd,
  input logic [3:0]        stat_rd,
  input logic [3:0]        rdata,
  input logic [7:0]        sel_q,
  input logic [BANK_W-1:0] bank_q
);
  p_addr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ld |=> sel_q == $past(sel_in));

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ld |=> $stable(sel_q));

  p_bank_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ld |=> bank_q == $past(bank_val));

  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ld |=> $stable(bank_q));

  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_rd && stat_rd == 4'b0) |=> $stable(rdata));
endmodule

bind nibram_banked nibram_banked_chk #(.BANK_W(BANK_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_ld   (sel_ld),
  .sel_in   (sel_in),
  .bank_ld  (bank_ld),
  .bank_val (bank_val),
  .main_rd  (main_rd),
  .stat_rd  (stat_rd),
  .rdata    (rdata),
  .sel_q    (sel_q),
  .bank_q   (bank_q)
);

// File: tb/test_nibram_banked.sv
module test_nibram_banked;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_ld = 1'b0;
  logic [7:0] sel_in = '0;
  logic       bank_ld = 1'b0;
  logic [2:0] bank_val = '0;
  logic       main_wr = 1'b0;
  logic       main_rd = 1'b0;
  logic [3:0] stat_wr = '0;
  logic [3:0] stat_rd = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nibram_banked i_nibram_banked (
    .clk(clk), .rst_n(rst_n), .sel_ld(sel_ld), .sel_in(sel_in),
    .bank_ld(bank_ld), .bank_val(bank_val), .main_wr(main_wr),
    .main_rd(main_rd), .stat_wr(stat_wr), .stat_rd(stat_rd),
    .wdata(wdata), .rdata(rdata)
  );

  localparam logic [2:0] LDA = 3'd0, LDB = 3'd1, WRM = 3'd2, RDM = 3'd3, WRS = 3'd4, RDS = 3'd5;
  localparam int NV = 33;
  // fields: op, arg, data, expected, requirement number
  localparam logic [22:0] VEC [NV] = '{
    {LDA, 8'h00, 4'h0, 4'h0, 4'd0}, {WRM, 8'h00, 4'h3, 4'h0, 4'd0},
    {LDA, 8'h01, 4'h0, 4'h0, 4'd0}, {WRM, 8'h00, 4'h9, 4'h0, 4'd0},
    {LDA, 8'h00, 4'h0, 4'h0, 4'd0}, {RDM, 8'h00, 4'h0, 4'h3, 4'd1},  // R1
    {LDA, 8'h01, 4'h0, 4'h0, 4'd0}, {RDM, 8'h00, 4'h0, 4'h9, 4'd1},  // R1
    {LDA, 8'h40, 4'h0, 4'h0, 4'd0}, {WRM, 8'h00, 4'h5, 4'h0, 4'd0},
    {LDA, 8'h10, 4'h0, 4'h0, 4'd0}, {WRM, 8'h00, 4'h6, 4'h0, 4'd0},
    {LDA, 8'h40, 4'h0, 4'h0, 4'd0}, {RDM, 8'h00, 4'h0, 4'h5, 4'd2},  // R2 chip field
    {LDA, 8'h10, 4'h0, 4'h0, 4'd0}, {RDM, 8'h00, 4'h0, 4'h6, 4'd2},  // R2 register field
    {LDB, 8'h02, 4'h0, 4'h0, 4'd0}, {LDA, 8'h00, 4'h0, 4'h0, 4'd0},
    {WRM, 8'h00, 4'hC, 4'h0, 4'd0}, {RDM, 8'h00, 4'h0, 4'hC, 4'd4},  // R4
    {LDB, 8'h00, 4'h0, 4'h0, 4'd0}, {RDM, 8'h00, 4'h0, 4'h3, 4'd4},  // R4
    {LDA, 8'h25, 4'h0, 4'h0, 4'd0}, {WRS, 8'h01, 4'h7, 4'h0, 4'd0},
    {WRS, 8'h02, 4'hA, 4'h0, 4'd0}, {RDS, 8'h01, 4'h0, 4'h7, 4'd6},  // R6
    {RDS, 8'h02, 4'h0, 4'hA, 4'd6},                                   // R6
    {LDA, 8'h2F, 4'h0, 4'h0, 4'd0}, {RDS, 8'h01, 4'h0, 4'h7, 4'd7},  // R7
    {LDA, 8'h25, 4'h0, 4'h0, 4'd0}, {WRM, 8'h00, 4'h1, 4'h0, 4'd0},
    {RDS, 8'h01, 4'h0, 4'h7, 4'd8}, {RDM, 8'h00, 4'h0, 4'h1, 4'd8}   // R8
  };

  task automatic drive(input logic ld, input logic [7:0] s, input logic bld, input logic [2:0] b,
                       input logic mw, input logic mr, input logic [3:0] sw, input logic [3:0] sr,
                       input logic [3:0] wd);
    @(negedge clk);
    sel_ld = ld; sel_in = s; bank_ld = bld; bank_val = b;
    main_wr = mw; main_rd = mr; stat_wr = sw; stat_rd = sr; wdata = wd;
    @(negedge clk);
    sel_ld = 1'b0; bank_ld = 1'b0; main_wr = 1'b0; main_rd = 1'b0;
    stat_wr = '0; stat_rd = '0;
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  task automatic lda(input logic [7:0] a);
    drive(1'b1, a, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0, 4'b0, 4'h0);
  endtask
  task automatic ldb(input logic [2:0] b);
    drive(1'b0, 8'h00, 1'b1, b, 1'b0, 1'b0, 4'b0, 4'b0, 4'h0);
  endtask
  task automatic wrm(input logic [3:0] d);
    drive(1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 4'b0, 4'b0, d);
  endtask
  task automatic rdm();
    drive(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 4'b0, 4'b0, 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 reset rdata", 4'h0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] arg;
      logic [3:0] dat, exp, tag;
      {op, arg, dat, exp, tag} = VEC[i];
      case (op)
        LDA: lda(arg);
        LDB: ldb(arg[2:0]);
        WRM: wrm(dat);
        RDM: rdm();
        WRS: drive(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 4'b1 << arg[1:0], 4'b0, dat);
        default: drive(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0, 4'b1 << arg[1:0], 4'h0);
      endcase
      if (op == RDM || op == RDS) check($sformatf("R%0d vector %0d", tag, i), exp);
    end

    // R5: a write without a read leaves rdata unchanged
    wrm(4'hF);
    check("R5 hold", 4'h1);

    // R10: a read and a write in the same cycle return the old content
    drive(1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1, 4'b0, 4'b0, 4'h4);
    check("R10 read-during-write", 4'hF);
    rdm();
    check("R10 after write", 4'h4);
    // R10: main read beats status read; the lowest status index wins
    drive(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 4'b0, 4'b0010, 4'h0);
    check("R10 main priority", 4'h4);
    drive(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0, 4'b0110, 4'h0);
    check("R10 lowest status", 4'h7);

    // R1: a read in the same cycle as an address load uses the old address
    drive(1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 4'b0, 4'b0, 4'h0);
    check("R1 same-cycle load", 4'h4);
    rdm();
    check("R1 new address", 4'h3);

    // R3: the highest bank is distinct from bank 0
    ldb(3'd7);
    wrm(4'hE);
    ldb(3'd0);
    rdm();
    check("R3 bank 0 intact", 4'h3);
    ldb(3'd7);
    rdm();
    check("R3 bank 7", 4'hE);

    // R9: reset clears bank, address and rdata but keeps memory
    ldb(3'd5);
    lda(8'h77);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R9 rdata after reset", 4'h0);
    rdm();
    check("R9 memory kept, bank and address zero", 4'h3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule